// File: doc/BRIEF.md
# Lower-Privilege Environment Configuration Register with Operation Gating

This block holds the 64-bit machine-level register through which the most privileged mode switches features on or off for supervisor and user software. The register sits at CSR address 0x30A and exists only when the hart implements user mode. Most of its bits are reserved and always read as zero. A few are single-bit enables. Two are two-bit fields whose illegal encodings are refused rather than stored.

Next to the storage sits a combinational gating checker. The decode stage tells it the current privilege and which gated operation is being attempted. Those operations are an access to the supervisor timer-compare CSR and the cache-block zero, clean, flush and invalidate operations. The checker answers whether the attempt must raise an illegal-instruction trap. For invalidate, it also says whether the operation is to be carried out as a flush. The checker raises the trap if any requested operation is denied. Machine mode is never gated.

All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake. A write through the CSR port takes effect at the next rising clock edge. Read data and the gating outputs are combinational from the stored value.

Top module: `envcfg_csr_gate`

## Requirements
- R1: After reset, every implemented field is zero. A read at 0x30A returns 0, and every enable output is 0.
- R2: The register responds only when `csr_addr` equals 0x30A and user mode is implemented (`HAS_UMODE`). Otherwise `csr_hit` is 0, `csr_rdata` is 0 and a write changes nothing.
- R3: Bits 59:45, 43:35, 32:8 and 3:1 always read as zero and ignore writes. A field whose feature parameter is 0 also reads as zero.
- R4: The single-bit fields take the written value at the next clock edge. These are: timer-compare enable (bit 63), page-attribute enable (62), hardware A/D update enable (61), counter-delegation enable (60), double-trap enable (44), cache-zero enable (7), cache clean/flush enable (6) and fence-I/O enable (0). Without a write that hits, the register holds its value.
- R5: The invalidate-mode field (bits 5:4) accepts 00, 01 and 11. A write of 10 leaves the field's previous value in place.
- R6: The pointer-masking field (bits 34:33) accepts 00, 10 and 11. A write of 01 leaves the field's previous value in place.
- R7: Privilege is encoded U=00, S=01, M=11. A timer-compare access is illegal from U. From S it is illegal when bit 63 is 0, and legal when bit 63 is 1.
- R8: From any privilege other than M, cache-zero is illegal when bit 7 is 0. Clean or flush is illegal when bit 6 is 0.
- R9: Invalidate from a privilege other than M depends on the invalidate-mode field. 00 makes it illegal. 01 allows it with `inval_as_flush`=1. 11 allows it with `inval_as_flush`=0.
- R10: In M mode, `trap_illegal` and `inval_as_flush` are 0 for every requested operation.
- R11: The enable outputs and the two field outputs mirror the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the current access |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_hit | output | 1 | Address selects this register and it exists |
| csr_rdata | output | 64 | Read data, zero on a miss |
| priv | input | 2 | Current privilege (U=00, S=01, M=11) |
| req_tmcmp | input | 1 | Timer-compare CSR access attempted |
| req_cbo_zero | input | 1 | Cache-block zero attempted |
| req_cbo_clean | input | 1 | Cache-block clean attempted |
| req_cbo_flush | input | 1 | Cache-block flush attempted |
| req_cbo_inval | input | 1 | Cache-block invalidate attempted |
| trap_illegal | output | 1 | A requested operation must raise illegal instruction |
| inval_as_flush | output | 1 | Invalidate is to be performed as flush |
| en_tmcmp | output | 1 | Timer-compare enable (bit 63) |
| en_pgattr | output | 1 | Page-attribute enable (bit 62) |
| en_hwad | output | 1 | Hardware A/D update enable (bit 61) |
| en_ctrdlg | output | 1 | Counter-delegation enable (bit 60) |
| en_dbltrap | output | 1 | Double-trap enable (bit 44) |
| ptr_mask_mode | output | 2 | Pointer-masking mode (bits 34:33) |
| en_cbo_zero | output | 1 | Cache-zero enable (bit 7) |
| en_cbo_mgmt | output | 1 | Clean/flush enable (bit 6) |
| cbo_inval_mode | output | 2 | Invalidate mode (bits 5:4) |
| en_fence_io | output | 1 | Fence-I/O enable (bit 0) |

## Verification
The bench writes the reserved encodings 10 and 01 into the two WARL fields after a legal value is already stored. A design that stored them blindly would read back the forbidden code. A design that cleared the field instead would read back 00.

An all-ones write must produce exactly the sparse implemented mask. Any reserved bit that leaks through would show up in that comparison, as would a parameter-disabled field that still stores.

The gating checks cover every privilege against every enable state, including the invalidate-as-flush setting. A checker that let M mode be gated, let U reach the timer compare, or confused allow with flush would flip `trap_illegal` or `inval_as_flush`.

Writes to a wrong address, and to a configuration without user mode, must leave the read value untouched.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;

  localparam int XLEN = 64;
  localparam logic [11:0] ENVCFG_ADDR = 12'h30A;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  // single-bit flags, index order 0..7
  localparam int NFLAG = 8;
  localparam int FLAG_POS [NFLAG] = '{0, 6, 7, 44, 60, 61, 62, 63};
  localparam int F_FENCEIO = 0;
  localparam int F_CBOMGMT = 1;
  localparam int F_CBOZERO = 2;
  localparam int F_DBLTRAP = 3;
  localparam int F_CTRDLG  = 4;
  localparam int F_HWAD    = 5;
  localparam int F_PGATTR  = 6;
  localparam int F_TMCMP   = 7;

  localparam int INV_LO = 4;
  localparam int PMM_LO = 33;

  localparam logic [1:0] INV_OFF   = 2'b00;
  localparam logic [1:0] INV_FLUSH = 2'b01;
  localparam logic [1:0] INV_RSV   = 2'b10;
  localparam logic [1:0] INV_FULL  = 2'b11;
  localparam logic [1:0] PMM_RSV   = 2'b01;

  function automatic logic [XLEN-1:0] flag_mask(logic [NFLAG-1:0] impl);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < NFLAG; i++) m[FLAG_POS[i]] = impl[i];
    return m;
  endfunction

endpackage

// File: rtl/envcfg_warl.sv
module envcfg_warl #(
  parameter int W = 2,
  parameter logic [W-1:0] RSV = '0
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] nxt_val
);
  // a reserved encoding never lands; the stored value stays
  always_comb nxt_val = (wr_val == RSV) ? old_val : wr_val;
endmodule

// File: rtl/envcfg_store.sv
module envcfg_store
  import envcfg_pkg::*;
#(
  parameter logic [XLEN-1:0] FLAG_MASK = '0,
  parameter bit HAS_INV = 1'b1,
  parameter bit HAS_PMM = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] word
);
  logic [XLEN-1:0] word_q, word_d;
  logic [1:0] inv_nxt, pmm_nxt;

  if (HAS_INV) begin : g_inv
    envcfg_warl #(.W(2), .RSV(INV_RSV)) u_inv (
      .old_val(word_q[INV_LO+:2]),
      .wr_val (wdata[INV_LO+:2]),
      .nxt_val(inv_nxt)
    );
  end else begin : g_no_inv
    assign inv_nxt = 2'b00;
  end

  if (HAS_PMM) begin : g_pmm
    envcfg_warl #(.W(2), .RSV(PMM_RSV)) u_pmm (
      .old_val(word_q[PMM_LO+:2]),
      .wr_val (wdata[PMM_LO+:2]),
      .nxt_val(pmm_nxt)
    );
  end else begin : g_no_pmm
    assign pmm_nxt = 2'b00;
  end

  always_comb begin
    word_d = wdata & FLAG_MASK;
    word_d[INV_LO+:2] = inv_nxt;
    word_d[PMM_LO+:2] = pmm_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= word_d;
  end

  assign word = word_q;

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(word_q));
  a_r5_inv_never_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[INV_LO+:2] != INV_RSV);
  a_r6_pmm_never_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[PMM_LO+:2] != PMM_RSV);
endmodule

// File: rtl/envcfg_gate.sv
module envcfg_gate
  import envcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  priv_e      priv,
  input  logic       en_tmcmp,
  input  logic       en_cbo_zero,
  input  logic       en_cbo_mgmt,
  input  logic [1:0] inv_mode,
  input  logic       req_tmcmp,
  input  logic       req_cbo_zero,
  input  logic       req_cbo_clean,
  input  logic       req_cbo_flush,
  input  logic       req_cbo_inval,
  output logic       trap_illegal,
  output logic       inval_as_flush
);
  logic lower, deny_tm, deny_zero, deny_mgmt, deny_inv;

  always_comb begin
    lower     = (priv != PRIV_M);
    deny_tm   = req_tmcmp && ((priv == PRIV_U) || (lower && !en_tmcmp));
    deny_zero = req_cbo_zero && lower && !en_cbo_zero;
    deny_mgmt = (req_cbo_clean || req_cbo_flush) && lower && !en_cbo_mgmt;
    deny_inv  = req_cbo_inval && lower && (inv_mode == INV_OFF);
    trap_illegal   = deny_tm | deny_zero | deny_mgmt | deny_inv;
    inval_as_flush = req_cbo_inval && lower && (inv_mode == INV_FLUSH);
  end

  a_r10_machine_free: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_M) |-> (!trap_illegal && !inval_as_flush));
  a_r7_user_no_tmcmp: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_U && req_tmcmp) |-> trap_illegal);
  a_r9_flush_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    inval_as_flush |-> (req_cbo_inval && inv_mode == INV_FLUSH));
endmodule

// File: rtl/envcfg_csr_gate.sv
module envcfg_csr_gate
  import envcfg_pkg::*;
#(
  parameter bit HAS_UMODE    = 1'b1,
  parameter bit HAS_TMCMP    = 1'b1,
  parameter bit HAS_PGATTR   = 1'b1,
  parameter bit HAS_HWAD     = 1'b1,
  parameter bit HAS_CTRDLG   = 1'b1,
  parameter bit HAS_DBLTRAP  = 1'b1,
  parameter bit HAS_PTRMASK  = 1'b1,
  parameter bit HAS_CBO_ZERO = 1'b1,
  parameter bit HAS_CBO_MGMT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic        csr_we,
  input  logic [63:0] csr_wdata,
  output logic        csr_hit,
  output logic [63:0] csr_rdata,
  input  logic [1:0]  priv,
  input  logic        req_tmcmp,
  input  logic        req_cbo_zero,
  input  logic        req_cbo_clean,
  input  logic        req_cbo_flush,
  input  logic        req_cbo_inval,
  output logic        trap_illegal,
  output logic        inval_as_flush,
  output logic        en_tmcmp,
  output logic        en_pgattr,
  output logic        en_hwad,
  output logic        en_ctrdlg,
  output logic        en_dbltrap,
  output logic [1:0]  ptr_mask_mode,
  output logic        en_cbo_zero,
  output logic        en_cbo_mgmt,
  output logic [1:0]  cbo_inval_mode,
  output logic        en_fence_io
);
  localparam logic [NFLAG-1:0] IMPL = {HAS_TMCMP, HAS_PGATTR, HAS_HWAD, HAS_CTRDLG,
                                       HAS_DBLTRAP, HAS_CBO_ZERO, HAS_CBO_MGMT, 1'b1}
                                      & {NFLAG{HAS_UMODE}};
  localparam logic [XLEN-1:0] FMASK = flag_mask(IMPL);

  logic [XLEN-1:0] word;

  assign csr_hit = HAS_UMODE && (csr_addr == ENVCFG_ADDR);

  envcfg_store #(
    .FLAG_MASK(FMASK),
    .HAS_INV  (HAS_UMODE && HAS_CBO_MGMT),
    .HAS_PMM  (HAS_UMODE && HAS_PTRMASK)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (csr_we && csr_hit),
    .wdata(csr_wdata),
    .word (word)
  );

  assign csr_rdata      = csr_hit ? word : '0;
  assign en_tmcmp       = word[FLAG_POS[F_TMCMP]];
  assign en_pgattr      = word[FLAG_POS[F_PGATTR]];
  assign en_hwad        = word[FLAG_POS[F_HWAD]];
  assign en_ctrdlg      = word[FLAG_POS[F_CTRDLG]];
  assign en_dbltrap     = word[FLAG_POS[F_DBLTRAP]];
  assign en_cbo_zero    = word[FLAG_POS[F_CBOZERO]];
  assign en_cbo_mgmt    = word[FLAG_POS[F_CBOMGMT]];
  assign en_fence_io    = word[FLAG_POS[F_FENCEIO]];
  assign ptr_mask_mode  = word[PMM_LO+:2];
  assign cbo_inval_mode = word[INV_LO+:2];

  envcfg_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .priv          (priv_e'(priv)),
    .en_tmcmp      (en_tmcmp),
    .en_cbo_zero   (en_cbo_zero),
    .en_cbo_mgmt   (en_cbo_mgmt),
    .inv_mode      (cbo_inval_mode),
    .req_tmcmp     (req_tmcmp),
    .req_cbo_zero  (req_cbo_zero),
    .req_cbo_clean (req_cbo_clean),
    .req_cbo_flush (req_cbo_flush),
    .req_cbo_inval (req_cbo_inval),
    .trap_illegal  (trap_illegal),
    .inval_as_flush(inval_as_flush)
  );

  a_r2_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit |=> $stable(word));
endmodule

// File: tb/test_envcfg_csr_gate.sv
`timescale 1ns/1ps
module test_envcfg_csr_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0] csr_addr = 12'h30A;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  priv = 2'b11;
  logic tm = 0, cz = 0, cc = 0, cf = 0, ci = 0;

  logic hit_a, hit_b, hit_c, ill_a, fl_a, ill_b, fl_b, ill_c, fl_c;
  logic [63:0] rd_a, rd_b, rd_c;
  logic [11:0] en_a, en_b, en_c;

  envcfg_csr_gate i_envcfg_csr_gate (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_hit(hit_a), .csr_rdata(rd_a), .priv(priv), .req_tmcmp(tm), .req_cbo_zero(cz),
    .req_cbo_clean(cc), .req_cbo_flush(cf), .req_cbo_inval(ci), .trap_illegal(ill_a),
    .inval_as_flush(fl_a), .en_tmcmp(en_a[11]), .en_pgattr(en_a[10]), .en_hwad(en_a[9]),
    .en_ctrdlg(en_a[8]), .en_dbltrap(en_a[7]), .ptr_mask_mode(en_a[3:2]),
    .en_cbo_zero(en_a[6]), .en_cbo_mgmt(en_a[5]), .cbo_inval_mode(en_a[1:0]),
    .en_fence_io(en_a[4]));

  envcfg_csr_gate #(.HAS_PGATTR(1'b0), .HAS_DBLTRAP(1'b0), .HAS_PTRMASK(1'b0),
                    .HAS_CBO_MGMT(1'b0)) i_envcfg_csr_gate_min (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_hit(hit_b), .csr_rdata(rd_b), .priv(priv), .req_tmcmp(tm), .req_cbo_zero(cz),
    .req_cbo_clean(cc), .req_cbo_flush(cf), .req_cbo_inval(ci), .trap_illegal(ill_b),
    .inval_as_flush(fl_b), .en_tmcmp(en_b[11]), .en_pgattr(en_b[10]), .en_hwad(en_b[9]),
    .en_ctrdlg(en_b[8]), .en_dbltrap(en_b[7]), .ptr_mask_mode(en_b[3:2]),
    .en_cbo_zero(en_b[6]), .en_cbo_mgmt(en_b[5]), .cbo_inval_mode(en_b[1:0]),
    .en_fence_io(en_b[4]));

  envcfg_csr_gate #(.HAS_UMODE(1'b0)) i_envcfg_csr_gate_nou (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_hit(hit_c), .csr_rdata(rd_c), .priv(priv), .req_tmcmp(tm), .req_cbo_zero(cz),
    .req_cbo_clean(cc), .req_cbo_flush(cf), .req_cbo_inval(ci), .trap_illegal(ill_c),
    .inval_as_flush(fl_c), .en_tmcmp(en_c[11]), .en_pgattr(en_c[10]), .en_hwad(en_c[9]),
    .en_ctrdlg(en_c[8]), .en_dbltrap(en_c[7]), .ptr_mask_mode(en_c[3:2]),
    .en_cbo_zero(en_c[6]), .en_cbo_mgmt(en_c[5]), .cbo_inval_mode(en_c[1:0]),
    .en_fence_io(en_c[4]));

  // kinds: 0 main read, 1 main gate, 2 reduced read, 3 no-user read, 4 main enables
  typedef struct {
    int          kind;
    logic [64:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [64:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {hit_a, rd_a};
        1: act = {63'd0, ill_a, fl_a};
        2: act = {hit_b, rd_b};
        3: act = {hit_c, rd_c};
        default: act = {53'd0, en_a};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(int kind, logic [64:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk); #1;
    csr_we = 1'b0; csr_addr = 12'h30A;
  endtask

  task automatic gchk(logic [1:0] p, logic [4:0] ops, logic [1:0] exp, string tag);
    priv = p; {tm, cz, cc, cf, ci} = ops;
    chk(1, {63'd0, exp}, tag);
    {tm, cz, cc, cf, ci} = 5'b0;
  endtask

  localparam logic [63:0] ALL_IMPL = 64'hF000_1006_0000_00F1;
  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(0, {1'b1, 64'd0}, "R1 reset read");
    chk(4, 65'd0, "R1 reset enables");
    gchk(S, 5'b10000, 2'b10, "R1 reset S timer access");

    wr(12'h30A, '1);
    chk(0, {1'b1, ALL_IMPL}, "R3 all-ones write mask");
    chk(4, {53'd0, 12'hFFF}, "R11 enables after all ones");
    chk(2, {1'b1, 64'hB000_0000_0000_0081}, "R3 absent fields read zero");
    chk(3, 65'd0, "R2 no user mode reads zero");

    csr_addr = 12'h30B;
    chk(0, 65'd0, "R2 wrong address reads zero");
    wr(12'h30B, '0);
    chk(0, {1'b1, ALL_IMPL}, "R2 wrong address write ignored");

    wr(12'h30A, '0);
    chk(0, {1'b1, 64'd0}, "R4 clear all");
    wr(12'h30A, 64'h0000_0000_0000_0002);
    chk(0, {1'b1, 64'd0}, "R3 reserved bit 1 ignored");
    wr(12'h30A, 64'h8000_1000_0000_0001);
    chk(0, {1'b1, 64'h8000_1000_0000_0001}, "R4 single bits land");
    chk(4, {53'd0, 12'h890}, "R11 enables follow bits");

    wr(12'h30A, 64'h10);
    chk(0, {1'b1, 64'h10}, "R5 invalidate mode 01");
    wr(12'h30A, 64'h20);
    chk(0, {1'b1, 64'h10}, "R5 reserved 10 keeps 01");
    wr(12'h30A, 64'h30);
    chk(0, {1'b1, 64'h30}, "R5 invalidate mode 11");
    wr(12'h30A, 64'h20);
    chk(0, {1'b1, 64'h30}, "R5 reserved 10 keeps 11");

    wr(12'h30A, 64'h4_0000_0000);
    chk(0, {1'b1, 64'h4_0000_0000}, "R6 pointer mask 10");
    wr(12'h30A, 64'h2_0000_0000);
    chk(0, {1'b1, 64'h4_0000_0000}, "R6 reserved 01 keeps 10");
    wr(12'h30A, 64'h6_0000_0000);
    chk(0, {1'b1, 64'h6_0000_0000}, "R6 pointer mask 11");

    wr(12'h30A, '0);
    gchk(S, 5'b10000, 2'b10, "R7 S timer blocked");
    gchk(S, 5'b01000, 2'b10, "R8 S zero blocked");
    gchk(U, 5'b00100, 2'b10, "R8 U clean blocked");
    gchk(S, 5'b00010, 2'b10, "R8 S flush blocked");
    gchk(S, 5'b00001, 2'b10, "R9 S invalidate off");
    gchk(M, 5'b11111, 2'b00, "R10 machine never gated");
    gchk(S, 5'b00000, 2'b00, "R10 no request no trap");

    wr(12'h30A, 64'h8000_0000_0000_0000);
    gchk(S, 5'b10000, 2'b00, "R7 S timer allowed");
    gchk(U, 5'b10000, 2'b10, "R7 U timer always blocked");
    wr(12'h30A, 64'h80);
    gchk(S, 5'b01000, 2'b00, "R8 S zero allowed");
    gchk(S, 5'b00100, 2'b10, "R8 clean still blocked");
    wr(12'h30A, 64'h40);
    gchk(U, 5'b00110, 2'b00, "R8 U clean and flush allowed");
    wr(12'h30A, 64'h10);
    gchk(S, 5'b00001, 2'b01, "R9 invalidate as flush");
    gchk(M, 5'b00001, 2'b00, "R10 machine invalidate plain");
    wr(12'h30A, 64'h30);
    gchk(U, 5'b00001, 2'b00, "R9 full invalidate");
    wr(12'h30A, 64'h00);
    gchk(S, 5'b00001, 2'b10, "R9 invalidate back to off");

    repeat (2) @(posedge clk);
    done = 1;
    report();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule